// File: doc/BRIEF.md
# Stack-Switch Interrupt Shadow Controller

This block sits at the retire boundary of a simple in-order processor model. At every retired instruction it decides whether a pending event is taken at the boundary that follows. The events are a debug trap, a non-maskable interrupt or a maskable interrupt. When an event is taken, the block emits a one-cycle delivery strobe and an event code. It also keeps the interrupt-enable flag, because instructions set and clear it as they retire.

An instruction that writes the stack segment register opens a shadow that covers the next boundary. No event is taken there, so the instruction that follows can load the stack pointer before any event pushes onto a half-switched stack. The shadow may catch a debug trap raised by the segment write itself. That trap is kept and taken one boundary later, even if the instruction in between cleared the interrupt-enable flag or entered a handler. In that case the trap lands ahead of the handler's first instruction. The block flags this case on a status output so that the case can be observed.

Top module: `ssh_top`

## Requirements
- R1: A retire with `ret_ss_write`=1, when no shadow is open, opens the shadow. No delivery follows that retire. Pending events, including a debug trap raised by that same retire, are held and not dropped.
- R2: The next retire closes the shadow. At that retire, held events compete for delivery under the normal rules.
- R3: A debug trap raised by the segment-writing retire is delivered with the next retire. This holds even if that next instruction set `ret_if_clear` or `ret_handler_entry`.
- R4: `dlv_late_dbg` is 1 for exactly the delivery cycle of a debug trap that was held by the shadow when the instruction in between had `ret_handler_entry`=1. Otherwise it is 0.
- R5: A segment write that retires while the shadow is open does not extend the shadow. The boundary after it delivers normally.
- R6: At most one event is taken per boundary, with priority debug trap over NMI over maskable interrupt. The codes are 1 for a debug trap, 2 for NMI and 3 for a maskable interrupt. A debug trap raised by a retire outside the shadow is taken at that same boundary.
- R7: `irq_level` is a level and is not latched. It is taken only if the interrupt-enable flag is 1 after the retiring instruction has updated it. `ret_if_set` sets the flag. `ret_if_clear` or `ret_handler_entry` clears it, and the clear wins. Reset leaves the flag at 0.
- R8: A one-cycle `nmi_pulse` is latched until it is delivered, whether or not a retire happens in that cycle. The interrupt-enable flag does not gate it.
- R9: A delivery appears on the outputs in the cycle after the retire it belongs to, for exactly one cycle. No delivery appears in a cycle after a cycle without a retire.
- R10: Synchronous reset clears the shadow, all held events, the flag and every output. An NMI pulsed during reset is not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_ss_write | input | 1 | Retiring instruction writes the stack segment |
| ret_if_clear | input | 1 | Retiring instruction clears interrupt enable |
| ret_if_set | input | 1 | Retiring instruction sets interrupt enable |
| ret_handler_entry | input | 1 | Retiring instruction transfers into a handler |
| ret_dbg_trap | input | 1 | Retiring instruction raised a debug trap |
| irq_level | input | 1 | Maskable interrupt request, level |
| nmi_pulse | input | 1 | Non-maskable interrupt request, one-cycle pulse |
| dlv_valid | output | 1 | An event is taken at the last boundary |
| dlv_code | output | 2 | Event code: 1 debug, 2 NMI, 3 maskable |
| dlv_late_dbg | output | 1 | Held debug trap taken after a handler entry |

## Verification
The corner case is a debug trap held by the shadow that is released on the same boundary as a handler entry, which also clears the interrupt-enable flag while a maskable request is high. A directed sequence builds this case: a segment write with a trap, then a handler-entry retire with `irq_level` high. The expected result is debug code 1 with the late flag set, and no maskable delivery at the following boundary. A second overlap is a segment write that retires inside an open shadow while an NMI pulse arrives. That case is judged by whether the NMI comes out right after the second write rather than one boundary later. Random streams mix both cases with the other inputs and compare every cycle with a reference model in the bench.

// File: rtl/ssh_pkg.sv
package ssh_pkg;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        EV_NONE = 2'd0,
        EV_DBG  = 2'd1,
        EV_NMI  = 2'd2,
        EV_IRQ  = 2'd3
    } ev_code_t;

    typedef struct packed {
        logic valid;
        logic ss_write;
        logic if_clear;
        logic if_set;
        logic handler_entry;
        logic dbg_trap;
    } retire_t;

    function automatic logic next_if(input logic cur, input retire_t r);
        logic v;
        v = cur;
        if (r.valid && r.if_set) v = 1'b1;
        if (r.valid && (r.if_clear || r.handler_entry)) v = 1'b0;
        return v;
    endfunction
endpackage

// File: rtl/ssh_window.sv
module ssh_window
    import ssh_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  retire_t ret,
    output logic    arm,
    output logic    window_q,
    output logic    if_next,
    output logic    if_q
);
    assign arm     = ret.valid && ret.ss_write && !window_q;
    assign if_next = next_if(if_q, ret);

    always_ff @(posedge clk) begin
        if (rst) begin
            window_q <= 1'b0;
            if_q     <= 1'b0;
        end else if (ret.valid) begin
            window_q <= arm;
            if_q     <= if_next;
        end
    end

    AST_SHADOW_ONE_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (window_q && ret.valid) |=> !window_q); // R5
endmodule

// File: rtl/ssh_pending.sv
module ssh_pending
    import ssh_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  retire_t ret,
    input  logic    nmi_pulse,
    input  logic    arm,
    input  logic    take_dbg,
    input  logic    take_nmi,
    output logic    dbg_now,
    output logic    nmi_now,
    output logic    held_dbg
);
    logic dbg_q;
    logic nmi_q;
    logic held_q;

    assign dbg_now  = dbg_q || (ret.valid && ret.dbg_trap);
    assign nmi_now  = nmi_q || nmi_pulse;
    assign held_dbg = held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_q  <= 1'b0;
            nmi_q  <= 1'b0;
            held_q <= 1'b0;
        end else begin
            dbg_q <= dbg_now && !take_dbg;
            nmi_q <= nmi_now && !take_nmi;
            if (take_dbg)
                held_q <= 1'b0;
            else if (arm && ret.dbg_trap)
                held_q <= 1'b1;
        end
    end

    AST_NMI_KEPT: assert property (@(posedge clk) disable iff (rst)
        (nmi_pulse && !take_nmi) |=> nmi_q); // R8
endmodule

// File: rtl/ssh_arbiter.sv
module ssh_arbiter
    import ssh_pkg::*;
(
    input  logic     boundary,
    input  logic     dbg_now,
    input  logic     nmi_now,
    input  logic     irq_level,
    input  logic     if_next,
    output ev_code_t code,
    output logic     take_dbg,
    output logic     take_nmi
);
    always_comb begin
        code = EV_NONE;
        if (boundary) begin
            if (dbg_now)                code = EV_DBG;
            else if (nmi_now)           code = EV_NMI;
            else if (irq_level && if_next) code = EV_IRQ;
        end
        take_dbg = (code == EV_DBG);
        take_nmi = (code == EV_NMI);
    end
endmodule

// File: rtl/ssh_top.sv
module ssh_top
    import ssh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ret_valid,
    input  logic              ret_ss_write,
    input  logic              ret_if_clear,
    input  logic              ret_if_set,
    input  logic              ret_handler_entry,
    input  logic              ret_dbg_trap,
    input  logic              irq_level,
    input  logic              nmi_pulse,
    output logic              dlv_valid,
    output logic [CODE_W-1:0] dlv_code,
    output logic              dlv_late_dbg
);
    retire_t  ret;
    logic     arm, window_q, if_next, if_q;
    logic     dbg_now, nmi_now, held_dbg;
    logic     take_dbg, take_nmi, boundary;
    ev_code_t code;

    assign ret = '{valid: ret_valid, ss_write: ret_ss_write, if_clear: ret_if_clear,
                   if_set: ret_if_set, handler_entry: ret_handler_entry,
                   dbg_trap: ret_dbg_trap};
    assign boundary = ret_valid && !arm;

    ssh_window u_window (
        .clk(clk), .rst(rst), .ret(ret),
        .arm(arm), .window_q(window_q), .if_next(if_next), .if_q(if_q)
    );

    ssh_pending u_pending (
        .clk(clk), .rst(rst), .ret(ret), .nmi_pulse(nmi_pulse), .arm(arm),
        .take_dbg(take_dbg), .take_nmi(take_nmi),
        .dbg_now(dbg_now), .nmi_now(nmi_now), .held_dbg(held_dbg)
    );

    ssh_arbiter u_arbiter (
        .boundary(boundary), .dbg_now(dbg_now), .nmi_now(nmi_now),
        .irq_level(irq_level), .if_next(if_next),
        .code(code), .take_dbg(take_dbg), .take_nmi(take_nmi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dlv_valid    <= 1'b0;
            dlv_code     <= EV_NONE;
            dlv_late_dbg <= 1'b0;
        end else begin
            dlv_valid    <= (code != EV_NONE);
            dlv_code     <= code;
            dlv_late_dbg <= (code == EV_DBG) && held_dbg && ret_handler_entry;
        end
    end

    AST_SHADOW_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_ss_write && !window_q) |=> !dlv_valid); // R1
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !ret_valid |=> !dlv_valid); // R9
    AST_IRQ_NEEDS_IF: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && dlv_code == EV_IRQ) |-> if_q); // R7
    AST_LATE_IS_DBG: assert property (@(posedge clk) disable iff (rst)
        dlv_late_dbg |-> (dlv_valid && dlv_code == EV_DBG)); // R4
    AST_HELD_DBG_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (held_dbg && ret_valid) |=> (dlv_valid && dlv_code == EV_DBG)); // R3
endmodule

// File: tb/ssh_top_tb.sv
module ssh_top_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ret_valid = 0, ret_ss_write = 0, ret_if_clear = 0, ret_if_set = 0;
    logic ret_handler_entry = 0, ret_dbg_trap = 0, irq_level = 0, nmi_pulse = 0;
    logic dlv_valid;
    logic [1:0] dlv_code;
    logic dlv_late_dbg;

    int vectors = 0;
    int misses = 0;
    bit done = 0;

    // reference state
    bit m_if, m_win, m_nmi, m_dbg, m_held;

    always #4 clk = ~clk;

    ssh_top u_dut (
        .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_ss_write(ret_ss_write),
        .ret_if_clear(ret_if_clear), .ret_if_set(ret_if_set),
        .ret_handler_entry(ret_handler_entry), .ret_dbg_trap(ret_dbg_trap),
        .irq_level(irq_level), .nmi_pulse(nmi_pulse),
        .dlv_valid(dlv_valid), .dlv_code(dlv_code), .dlv_late_dbg(dlv_late_dbg)
    );

    task automatic compare(string tag, bit ev, logic [1:0] ec, bit el);
        vectors++;
        if (dlv_valid !== ev || dlv_code !== ec || dlv_late_dbg !== el) begin
            misses++;
            $display("FAIL %s: got valid=%0b code=%0d late=%0b, expected valid=%0b code=%0d late=%0b",
                     tag, dlv_valid, dlv_code, dlv_late_dbg, ev, ec, el);
        end
    endtask

    function automatic logic [1:0] pick(bit boundary, bit dbg, bit nmi, bit irq_ok);
        if (!boundary) return 2'd0;
        if (dbg) return 2'd1;       // R6 priority
        if (nmi) return 2'd2;
        if (irq_ok) return 2'd3;
        return 2'd0;
    endfunction

    // one cycle: drive at negedge, check at the following negedge
    task automatic step(bit v, bit ss, bit clr, bit set, bit hnd, bit dbg, bit irq, bit nmi);
        bit arm, bnd, dnow, nnow, ifn, late;
        logic [1:0] ec;
        string tag;
        ret_valid = v; ret_ss_write = ss; ret_if_clear = clr; ret_if_set = set;
        ret_handler_entry = hnd; ret_dbg_trap = dbg; irq_level = irq; nmi_pulse = nmi;
        arm  = v && ss && !m_win;
        bnd  = v && !arm;
        dnow = m_dbg || (v && dbg);
        nnow = m_nmi || nmi;
        ifn  = m_if;
        if (v && set) ifn = 1;
        if (v && (clr || hnd)) ifn = 0;            // R7
        ec   = pick(bnd, dnow, nnow, irq && ifn);
        late = (ec == 2'd1) && m_held && hnd;      // R4
        if (late) tag = "R4";
        else if (ec == 2'd1 && m_held) tag = "R3";
        else if (arm) tag = "R1";
        else if (v && ss && m_win) tag = "R5";
        else if (v && m_win) tag = "R2";
        else if (ec == 2'd3) tag = "R7";
        else if (ec == 2'd2) tag = "R8";
        else if (ec == 2'd1) tag = "R6";
        else tag = "R9";
        m_dbg = dnow && (ec != 2'd1);
        m_nmi = nnow && (ec != 2'd2);
        if (ec == 2'd1) m_held = 0;
        else if (arm && dbg) m_held = 1;
        if (v) begin m_win = arm; m_if = ifn; end
        @(posedge clk);
        @(negedge clk);
        compare(tag, ec != 2'd0, ec, late);
    endtask

    task automatic do_reset();
        rst = 1;
        ret_valid = 0; nmi_pulse = 1; irq_level = 1;
        @(posedge clk); @(negedge clk);
        nmi_pulse = 0;
        @(posedge clk); @(negedge clk);
        rst = 0;
        m_if = 0; m_win = 0; m_nmi = 0; m_dbg = 0; m_held = 0;
        compare("R10", 0, 2'd0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1597));
        @(negedge clk);
        do_reset();
        // R10: NMI pulsed during reset is gone; retire with IF=0 gives nothing
        step(1,0,0,0,0,0,1,0);
        // R7: enable then level irq delivered
        step(1,0,0,1,0,0,1,0);
        // R1 then R3/R4: trap on segment write, handler entry next, irq high
        step(1,1,0,0,0,1,1,0);
        step(1,0,1,0,1,0,1,0);
        step(1,0,0,0,0,0,1,0);        // R7: IF cleared by entry, no irq
        // R8: NMI with no retire, then taken with IF=0
        step(0,0,0,0,0,0,0,1);
        step(1,0,0,0,0,0,0,0);
        // R5: back-to-back segment writes, NMI arriving on the second
        step(1,1,0,0,0,0,0,0);
        step(1,1,0,0,0,0,0,1);
        step(1,0,0,0,0,0,0,0);
        // R2: NMI held through shadow, released on next retire
        step(1,1,0,0,0,0,0,1);
        step(1,0,0,0,0,0,0,0);
        // R6: all three at one boundary
        step(1,0,0,1,0,1,1,1);
        step(1,0,0,0,0,0,1,0);
        step(1,0,0,0,0,0,1,0);
        // R3 without handler entry: late flag stays 0
        step(1,1,0,0,0,1,0,0);
        step(1,0,1,0,0,0,0,0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit v, ss;
            v  = ($urandom % 4) != 0;
            ss = ($urandom % 4) == 0;
            step(v, ss, ($urandom % 6) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0,
                 ($urandom % 5) == 0, ($urandom % 2) == 0, ($urandom % 9) == 0);
            if (i == 2000) do_reset();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule